// File: doc/BRIEF.md
# Receive FIFO Idle Timeout and Threshold Interrupt Generator

This block sits beside the receive FIFO of a serial port and decides when the processor should be told that received data is waiting. It raises two interrupt lines. The threshold line rises when the FIFO occupancy is at or above a selectable fill level. The timeout line rises when at least one word is in the FIFO and nothing has happened for four character times. Here nothing happening means that no new character has arrived and the processor has not read the holding register.

The length of one character is computed live from the line format: one start bit, five to eight data bits, an optional parity bit, and one or two stop bits. Bit time is measured in system clocks with the divisor supplied from outside. If the format or the divisor changes, the timer starts over with the new period. The FIFO storage, the serial receiver and the divisor register live elsewhere. Their state arrives here as inputs.

A three-state machine controls the timeout. ST_EMPTY is the state while the FIFO is empty; the counters are held cleared. In ST_TIMING the block counts bit times. In ST_FIRED the timeout line is high. The transitions are:
- EMPTY→TIMING when the occupancy becomes nonzero.
- TIMING→TIMING with the counters cleared on a restart event (character strobe, read strobe, or format/divisor change).
- TIMING→FIRED when the count expires.
- FIRED→TIMING on a character or read strobe.
- TIMING→EMPTY and FIRED→EMPTY whenever the occupancy is zero.

Top module: `rxto_detect`

## Requirements
- R1: After reset both `rto_irq` and `trig_irq` are low.
- R2: With the timer restarted at clock edge k, `rto_irq` rises after edge k + 4·F·D and not before. F = 7 + `data_sel` + `parity_en` + `stop2`, where `data_sel` 0..3 selects 5..8 data bits. D = `divisor`, and a divisor of 0 acts as 1. Entering the data-present state counts as a restart.
- R3: While `fifo_level` is zero the timeout line never rises. A zero occupancy drops a raised timeout one cycle later.
- R4: A `char_rx` strobe restarts the timer, and it drops a raised timeout in the next cycle.
- R5: A `host_rd` strobe with data present restarts the timer, and it drops a raised timeout in the next cycle.
- R6: A change of `data_sel`, `parity_en`, `stop2` or `divisor` while timing restarts the timer at the edge where the new value is first sampled. The new period then applies.
- R7: `trig_irq` is registered. One cycle after `fifo_level` is at or above the threshold it is high, and otherwise low. The threshold is 1, 4, 8 or 14 for `trig_sel` 0, 1, 2 or 3.
- R8: The timeout runs and fires the same way whether or not the trigger threshold is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | LVL_W (5) | Current receive FIFO occupancy |
| char_rx | input | 1 | One-cycle strobe: a character was written into the FIFO |
| host_rd | input | 1 | One-cycle strobe: the processor read the holding register |
| data_sel | input | 2 | Data bits per character, 0..3 meaning 5..8 |
| parity_en | input | 1 | Parity bit present |
| stop2 | input | 1 | Two stop bits when set, one otherwise |
| divisor | input | DIV_W (16) | System clocks per bit time (0 treated as 1) |
| trig_sel | input | 2 | Threshold select: 1, 4, 8, 14 |
| rto_irq | output | 1 | Receive timeout interrupt |
| trig_irq | output | 1 | Threshold reached interrupt |

## Verification
The hardest behaviour to reach is a restart that lands in the middle of a long count. A late restart that the design missed would only show up as a timeout that fires early. The stimulus therefore sends a character strobe, a read strobe, or a divisor change partway through a period. It then counts edges from that exact edge to the rise of the timeout, so an off-by-one or a missed clear changes the measured count. The vector table walks several line formats and divisors, including divisor 0, so that every term of the character-length sum is exercised.

// File: rtl/rxto_pkg.sv
`timescale 1ns/1ps
package rxto_pkg;

    // Longest character: start + 8 data + parity + 2 stop.
    localparam int MAX_FRAME_BITS = 12;
    localparam int FRAME_W        = 4;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_TIMING = 2'd1,
        ST_FIRED  = 2'd2
    } rxto_state_e;

    typedef struct packed {
        logic [1:0] data_sel;
        logic       parity_en;
        logic       stop2;
    } line_fmt_t;

    // Bits on the wire for one character under the given format.
    function automatic logic [FRAME_W-1:0] frame_bits(input line_fmt_t f);
        logic [FRAME_W-1:0] n;
        n = FRAME_W'(7) + FRAME_W'(f.data_sel) + FRAME_W'(f.parity_en) + FRAME_W'(f.stop2);
        return n;
    endfunction

endpackage

// File: rtl/rxto_bitclk.sv
`timescale 1ns/1ps
module rxto_bitclk #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    always_comb begin
        last = (divisor == '0) ? '0 : divisor - DIV_W'(1);
        tick = !clear && (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (cnt >= last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/rxto_timer.sv
`timescale 1ns/1ps
module rxto_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        expire = !clear && tick && (cnt == limit - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear || expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/rxto_trigger.sv
`timescale 1ns/1ps
module rxto_trigger #(
    parameter int LVL_W = 5,
    parameter int TH0   = 1,
    parameter int TH1   = 4,
    parameter int TH2   = 8,
    parameter int TH3   = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [1:0]       sel,
    output logic             hit
);
    localparam int NSEL = 4;
    logic [LVL_W-1:0] thr [NSEL];
    logic [LVL_W-1:0] th_now;

    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_thr
            localparam int TV = (g == 0) ? TH0 : (g == 1) ? TH1 : (g == 2) ? TH2 : TH3;
            assign thr[g] = LVL_W'(TV);
        end
    endgenerate

    always_comb begin
        th_now = thr[sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit <= 1'b0;
        end else begin
            hit <= (level >= th_now);
        end
    end
endmodule

// File: rtl/rxto_detect.sv
`timescale 1ns/1ps
module rxto_detect
    import rxto_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
    parameter int DIV_W      = 16,
    parameter int CHAR_TIMES = 4,
    parameter int TH0        = 1,
    parameter int TH1        = 4,
    parameter int TH2        = 8,
    parameter int TH3        = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             char_rx,
    input  logic             host_rd,
    input  logic [1:0]       data_sel,
    input  logic             parity_en,
    input  logic             stop2,
    input  logic [DIV_W-1:0] divisor,
    input  logic [1:0]       trig_sel,
    output logic             rto_irq,
    output logic             trig_irq
);
    localparam int CNT_W = $clog2(CHAR_TIMES * MAX_FRAME_BITS + 1);
    localparam int CFG_W = $bits(line_fmt_t) + DIV_W;

    rxto_state_e      state, state_nx;
    line_fmt_t        fmt;
    logic [CFG_W-1:0] cfg_now, cfg_q;
    logic             cfg_chg;
    logic             level_nz;
    logic             restart;
    logic             run;
    logic             bit_tick;
    logic             expire;
    logic [CNT_W-1:0] limit;

    always_comb begin
        fmt       = '{data_sel: data_sel, parity_en: parity_en, stop2: stop2};
        cfg_now   = {fmt, divisor};
        cfg_chg   = (cfg_now != cfg_q);
        level_nz  = (fifo_level != '0);
        restart   = char_rx || host_rd || cfg_chg;
        run       = (state == ST_TIMING) && level_nz && !restart;
        limit     = CNT_W'(CHAR_TIMES) * CNT_W'(frame_bits(fmt));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_now;
        end
    end

    rxto_bitclk #(.DIV_W(DIV_W)) u_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!run),
        .divisor (divisor),
        .tick    (bit_tick)
    );

    rxto_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!run),
        .tick   (bit_tick),
        .limit  (limit),
        .expire (expire)
    );

    rxto_trigger #(
        .LVL_W (LVL_W),
        .TH0   (TH0),
        .TH1   (TH1),
        .TH2   (TH2),
        .TH3   (TH3)
    ) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .level (fifo_level),
        .sel   (trig_sel),
        .hit   (trig_irq)
    );

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: begin
                if (level_nz) state_nx = ST_TIMING;
            end
            ST_TIMING: begin
                if (!level_nz)    state_nx = ST_EMPTY;
                else if (restart) state_nx = ST_TIMING;
                else if (expire)  state_nx = ST_FIRED;
            end
            ST_FIRED: begin
                if (!level_nz)                state_nx = ST_EMPTY;
                else if (char_rx || host_rd)  state_nx = ST_TIMING;
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    // Output decode.
    always_comb begin
        rto_irq = (state == ST_FIRED);
    end
endmodule

// File: rtl/rxto_checker.sv
`timescale 1ns/1ps
module rxto_checker #(
    parameter int LVL_W = 5,
    parameter int TH0   = 1,
    parameter int TH1   = 4,
    parameter int TH2   = 8,
    parameter int TH3   = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] fifo_level,
    input logic             char_rx,
    input logic             host_rd,
    input logic [1:0]       trig_sel,
    input logic             rto_irq,
    input logic             trig_irq
);
    logic [LVL_W-1:0] th_sel;
    always_comb begin
        case (trig_sel)
            2'd0:    th_sel = LVL_W'(TH0);
            2'd1:    th_sel = LVL_W'(TH1);
            2'd2:    th_sel = LVL_W'(TH2);
            default: th_sel = LVL_W'(TH3);
        endcase
    end

    AST_EMPTY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == '0) |=> !rto_irq);  // R3

    AST_RISE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rto_irq) |-> ($past(fifo_level) != '0));  // R3

    AST_CHAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        char_rx |=> !rto_irq);  // R4

    AST_READ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> !rto_irq);  // R5

    AST_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rto_irq) |-> $past(!char_rx && !host_rd));  // R4

    AST_TRIG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level >= th_sel) |=> trig_irq);  // R7

    AST_TRIG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level < th_sel) |=> !trig_irq);  // R7
endmodule

bind rxto_detect rxto_checker #(
    .LVL_W (LVL_W),
    .TH0   (TH0),
    .TH1   (TH1),
    .TH2   (TH2),
    .TH3   (TH3)
) u_rxto_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_level (fifo_level),
    .char_rx    (char_rx),
    .host_rd    (host_rd),
    .trig_sel   (trig_sel),
    .rto_irq    (rto_irq),
    .trig_irq   (trig_irq)
);

// File: tb/tb_rxto_detect.sv
`timescale 1ns/1ps
module tb_rxto_detect;
    localparam int LVL_W = 5;
    localparam int DIV_W = 16;
    localparam int NVEC  = 7;

    // {data_sel[2], parity[1], stop2[1], divisor[16], expected edges[16]}
    localparam logic [35:0] VEC [NVEC] = '{
        {2'd3, 1'b0, 1'b0, 16'd1, 16'd40},
        {2'd3, 1'b0, 1'b0, 16'd3, 16'd120},
        {2'd0, 1'b0, 1'b0, 16'd2, 16'd56},
        {2'd2, 1'b1, 1'b0, 16'd2, 16'd80},
        {2'd3, 1'b1, 1'b1, 16'd1, 16'd48},
        {2'd1, 1'b0, 1'b1, 16'd4, 16'd144},
        {2'd3, 1'b0, 1'b0, 16'd0, 16'd40}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] fifo_level = '0;
    logic             char_rx = 1'b0;
    logic             host_rd = 1'b0;
    logic [1:0]       data_sel = 2'd3;
    logic             parity_en = 1'b0;
    logic             stop2 = 1'b0;
    logic [DIV_W-1:0] divisor = 16'd1;
    logic [1:0]       trig_sel = 2'd3;
    logic             rto_irq;
    logic             trig_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rxto_detect dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_level (fifo_level),
        .char_rx    (char_rx),
        .host_rd    (host_rd),
        .data_sel   (data_sel),
        .parity_en  (parity_en),
        .stop2      (stop2),
        .divisor    (divisor),
        .trig_sel   (trig_sel),
        .rto_irq    (rto_irq),
        .trig_irq   (trig_irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Count edges after the restart edge until rto_irq is seen high.
    task automatic measure(output int n);
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (rto_irq) break;
        end
    endtask

    task automatic strobe_char();
        char_rx = 1'b1;
        @(posedge clk);
        @(negedge clk);
        char_rx = 1'b0;
    endtask

    task automatic strobe_read();
        host_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic arrive(input int lvl);
        fifo_level = LVL_W'(lvl);
        strobe_char();
    endtask

    task automatic drain();
        fifo_level = '0;
        cyc(3);
    endtask

    initial begin
        int n;
        int ths [4];
        ths = '{1, 4, 8, 14};
        @(negedge clk);
        cyc(3);
        check(!rto_irq && !trig_irq, "R1 reset outputs", {rto_irq, trig_irq}, 0);
        rst_n = 1'b1;
        cyc(2);
        check(!rto_irq && !trig_irq, "R1 after release", {rto_irq, trig_irq}, 0);

        // Table of formats and divisors.
        for (int v = 0; v < NVEC; v++) begin
            {data_sel, parity_en, stop2, divisor} = VEC[v][35:16];
            cyc(3);
            arrive(1);
            measure(n);
            check(n == int'(VEC[v][15:0]), $sformatf("R2 vector %0d period", v), n, int'(VEC[v][15:0]));
            drain();
        end

        // Directed: 8N1, divisor 1, period 40.
        data_sel = 2'd3; parity_en = 1'b0; stop2 = 1'b0; divisor = 16'd1;
        cyc(3);

        arrive(1);
        cyc(25);
        arrive(2);
        measure(n);
        check(n == 40, "R4 char restarts mid count", n, 40);

        strobe_char();
        check(!rto_irq, "R4 char drops timeout", rto_irq, 0);
        measure(n);
        check(n == 40, "R4 period after char in fired", n, 40);

        strobe_read();
        check(!rto_irq, "R5 read drops timeout", rto_irq, 0);
        cyc(20);
        strobe_read();
        measure(n);
        check(n == 40, "R5 read restarts mid count", n, 40);

        fifo_level = '0;
        cyc(1);
        check(!rto_irq, "R3 empty drops timeout", rto_irq, 0);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            cyc(1);
            if (rto_irq) n++;
        end
        check(n == 0, "R3 no timeout while empty", n, 0);

        // R6: divisor change mid count.
        arrive(1);
        cyc(10);
        divisor = 16'd2;
        @(posedge clk);
        @(negedge clk);
        measure(n);
        check(n == 80, "R6 divisor change restarts", n, 80);
        drain();

        // R6: format change mid count (8N1 -> 8 with parity, 12 bits... stop2 only: 11 bits).
        divisor = 16'd1;
        cyc(2);
        arrive(1);
        cyc(15);
        stop2 = 1'b1;
        @(posedge clk);
        @(negedge clk);
        measure(n);
        check(n == 44, "R6 format change restarts", n, 44);
        drain();
        stop2 = 1'b0;

        // R7 thresholds.
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            fifo_level = LVL_W'(ths[s] - 1);
            cyc(1);
            check(!trig_irq, $sformatf("R7 below threshold sel %0d", s), trig_irq, 0);
            fifo_level = LVL_W'(ths[s]);
            cyc(1);
            check(trig_irq, $sformatf("R7 at threshold sel %0d", s), trig_irq, 1);
        end
        drain();
        check(!trig_irq, "R7 empty clears trigger", trig_irq, 0);

        // R8: timeout unaffected by trigger state.
        trig_sel = 2'd0;
        arrive(14);
        check(trig_irq, "R8 trigger reached", trig_irq, 1);
        measure(n);
        check(n == 40, "R8 timeout with trigger reached", n, 40);
        drain();
        trig_sel = 2'd3;
        arrive(3);
        check(!trig_irq, "R8 trigger not reached", trig_irq, 0);
        measure(n);
        check(n == 40, "R8 timeout with trigger not reached", n, 40);
        drain();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule